// File: doc/BRIEF.md
# Enable-Gated Service Watchdog with Backup Flag

This block watches a periodic service signal from a controller and lowers an active-low backup flag when that service stops. A backup or safety circuit can then take over. The watchdog runs only while an enable-valid input is high. While that input is low, the block is idle, the flag is held high and all internal counts are cleared.

Every time enable-valid goes from low to high, the first timing window is longer: it lasts `EXT_MULT` (eight by default) times the normal period `PERIOD_TICKS`. This gives the controller time to start up. The first service falling edge switches timing to the normal period at once. If the long window runs out with no service edge, the flag drops and stays low, and the timer stops until a service edge arrives.

In normal operation, the flag drops after `MISS_LIMIT` full periods in a row pass with no service edge. It is released after `GOOD_LIMIT` service edges in a row arrive with no timeout between them.

Top module: `wdg_backup_top`

## Requirements
- R1: While en_valid_i is low, backup_n_o is high one cycle later and stays high, and service activity has no effect. A low en_valid_i also clears every count, so a fault state present before the low does not survive it.
- R2: In the first cycle that en_valid_i is sampled high after being low, the extended window starts. With no service edge, backup_n_o stays high for PERIOD_TICKS*EXT_MULT cycles after that first high sample.
- R3: A service falling edge during the extended window switches timing to the normal period at once. With no further edges, the flag then falls MISS_LIMIT*PERIOD_TICKS cycles after that edge.
- R4: When the extended window expires with no service edge, backup_n_o goes low in the next cycle. It then stays low, with no timing, until a service edge arrives.
- R5: After such an expiry, the first service falling edge starts normal-period timing. That edge also counts as the first good edge toward release.
- R6: In normal timing, backup_n_o goes low after MISS_LIMIT consecutive periods of PERIOD_TICKS cycles each with no service edge. The timer restarts from zero after each timeout.
- R7: A low flag is released after GOOD_LIMIT service edges with no timeout between them. Any timeout restarts that count from zero.
- R8: A service falling edge is a sample of svc_i high followed by a sample low on the next clock. Each such edge clears the period timer and the count of missed periods.
- R9: When a service edge and a timeout fall on the same cycle, the service edge wins and no timeout is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_valid_i | input | 1 | Watchdog enable; a rising edge starts the extended window |
| svc_i | input | 1 | Service signal; falling edges kick the watchdog |
| backup_n_o | output | 1 | Backup flag, active low, registered |

## Verification
A wrong period count shows at backup_n_o as a flag edge that comes early or late. It appears within one extended window, or within MISS_LIMIT normal periods, of the error. A lost or stuck state shows up in the next phase change. Examples are a flag that fails to drop after the extended window, a parked timer that keeps counting, or a release that comes too soon after an intervening timeout. The reference model is compared on every cycle, so the first cycle where the flag differs is reported.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_EXT  = 2'd1,
    WD_PARK = 2'd2,
    WD_RUN  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdg_fall_det.sv
module wdg_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/wdg_period_timer.sv
module wdg_period_timer #(
  parameter int PERIOD_TICKS = 16,
  parameter int EXT_MULT     = 8,
  localparam int EXT_TICKS   = PERIOD_TICKS * EXT_MULT,
  localparam int CNT_W       = $clog2(EXT_TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_i,
  input  logic             clear_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LastNorm = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] LastExt  = CNT_W'(EXT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = ext_i ? LastExt : LastNorm;
  assign expire_o = run_i && (cnt_q == last);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i || !run_i || expire_o) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_fault_tracker.sv
module wdg_fault_tracker #(
  parameter int MISS_LIMIT = 3,
  parameter int GOOD_LIMIT = 3,
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1),
  localparam int GOOD_W    = $clog2(GOOD_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              off_i,
  input  logic              ext_expire_i,
  input  logic              run_expire_i,
  input  logic              good_edge_i,
  output logic              flag_n_o,
  output logic [GOOD_W-1:0] good_cnt_o
);
  localparam logic [MISS_W-1:0] MissLast = MISS_W'(MISS_LIMIT - 1);
  localparam logic [GOOD_W-1:0] GoodLast = GOOD_W'(GOOD_LIMIT - 1);

  logic              flag_q;
  logic [MISS_W-1:0] miss_q;
  logic [GOOD_W-1:0] good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b1;
      miss_q <= '0;
      good_q <= '0;
    end else if (off_i) begin
      flag_q <= 1'b1;
      miss_q <= '0;
      good_q <= '0;
    end else if (ext_expire_i) begin
      flag_q <= 1'b0;
      miss_q <= '0;
      good_q <= '0;
    end else if (good_edge_i) begin
      miss_q <= '0;
      if (!flag_q) begin
        if (good_q == GoodLast) begin
          flag_q <= 1'b1;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else if (run_expire_i) begin
      good_q <= '0;
      if (miss_q == MissLast) flag_q <= 1'b0;
      else                    miss_q <= miss_q + 1'b1;
    end
  end

  assign flag_n_o   = flag_q;
  assign good_cnt_o = good_q;
endmodule

// File: rtl/wdg_backup_top.sv
module wdg_backup_top #(
  parameter int PERIOD_TICKS = 16,
  parameter int EXT_MULT     = 8,
  parameter int MISS_LIMIT   = 3,
  parameter int GOOD_LIMIT   = 3,
  localparam int CNT_W       = $clog2(PERIOD_TICKS * EXT_MULT),
  localparam int GOOD_W      = $clog2(GOOD_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_valid_i,
  input  logic svc_i,
  output logic backup_n_o
);
  import wdg_pkg::*;

  wd_state_e         state_q, state_d;
  logic              svc_fall;
  logic              tmr_run, tmr_ext, tmr_clear, tmr_expire;
  logic [CNT_W-1:0]  tmr_count;
  logic              ext_expire, run_expire, good_edge;
  logic [GOOD_W-1:0] good_cnt;

  wdg_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (svc_i),
    .fall_o (svc_fall)
  );

  always_comb begin
    state_d   = state_q;
    tmr_clear = 1'b0;
    if (!en_valid_i) begin
      state_d   = WD_OFF;
      tmr_clear = 1'b1;
    end else begin
      unique case (state_q)
        WD_OFF:  state_d = WD_EXT;
        WD_EXT: begin
          if (svc_fall) begin
            state_d   = WD_RUN;
            tmr_clear = 1'b1;
          end else if (tmr_expire) begin
            state_d = WD_PARK;
          end
        end
        WD_PARK: begin
          if (svc_fall) begin
            state_d   = WD_RUN;
            tmr_clear = 1'b1;
          end
        end
        WD_RUN:  tmr_clear = svc_fall;
        default: state_d = WD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WD_OFF;
    else         state_q <= state_d;
  end

  assign tmr_run = en_valid_i && (state_q == WD_EXT || state_q == WD_RUN);
  assign tmr_ext = (state_q == WD_EXT);

  wdg_period_timer #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .EXT_MULT     (EXT_MULT)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tmr_run),
    .ext_i    (tmr_ext),
    .clear_i  (tmr_clear),
    .expire_o (tmr_expire),
    .count_o  (tmr_count)
  );

  // service edge outranks a coincident timeout
  assign ext_expire = tmr_expire && !svc_fall && (state_q == WD_EXT);
  assign run_expire = tmr_expire && !svc_fall && (state_q == WD_RUN);
  assign good_edge  = en_valid_i && svc_fall &&
                      (state_q == WD_RUN || state_q == WD_PARK);

  wdg_fault_tracker #(
    .MISS_LIMIT (MISS_LIMIT),
    .GOOD_LIMIT (GOOD_LIMIT)
  ) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .off_i        (!en_valid_i),
    .ext_expire_i (ext_expire),
    .run_expire_i (run_expire),
    .good_edge_i  (good_edge),
    .flag_n_o     (backup_n_o),
    .good_cnt_o   (good_cnt)
  );
endmodule

// File: rtl/wdg_backup_chk.sv
module wdg_backup_chk #(
  parameter int PERIOD_TICKS = 16,
  parameter int EXT_MULT     = 8,
  localparam int CNT_W       = $clog2(PERIOD_TICKS * EXT_MULT)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_valid_i,
  input logic             backup_n_o,
  input logic [1:0]       state_q,
  input logic             svc_fall,
  input logic             tmr_expire,
  input logic [CNT_W-1:0] tmr_count
);
  localparam logic [1:0] SOff  = 2'd0;
  localparam logic [1:0] SExt  = 2'd1;
  localparam logic [1:0] SPark = 2'd2;
  localparam logic [1:0] SRun  = 2'd3;
  localparam int EXT_TICKS = PERIOD_TICKS * EXT_MULT;

  p_off_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_valid_i |=> (backup_n_o && state_q == SOff));

  p_ext_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SOff && en_valid_i) |=> (state_q == SExt && tmr_count == '0 && backup_n_o));

  p_ext_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SExt) |-> (int'(tmr_count) < EXT_TICKS));

  p_ext_kick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SExt && en_valid_i && svc_fall) |=> (state_q == SRun && tmr_count == '0 && backup_n_o));

  p_ext_expire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SExt && en_valid_i && !svc_fall && tmr_expire) |=> (state_q == SPark && !backup_n_o));

  p_park_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SPark && en_valid_i && !svc_fall) |=> (state_q == SPark && !backup_n_o && tmr_count == '0));

  p_park_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SPark && en_valid_i && svc_fall) |=> (state_q == SRun && tmr_count == '0));

  p_run_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRun) |-> (int'(tmr_count) < PERIOD_TICKS));

  p_fall_needs_timeout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(backup_n_o) |-> $past(tmr_expire && !svc_fall && en_valid_i));

  p_rise_needs_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(backup_n_o) |-> $past(svc_fall || !en_valid_i));

  p_edge_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_valid_i && svc_fall && state_q != SOff) |=> (tmr_count == '0));
endmodule

bind wdg_backup_top wdg_backup_chk #(
  .PERIOD_TICKS (PERIOD_TICKS),
  .EXT_MULT     (EXT_MULT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_valid_i (en_valid_i),
  .backup_n_o (backup_n_o),
  .state_q    (state_q),
  .svc_fall   (svc_fall),
  .tmr_expire (tmr_expire),
  .tmr_count  (tmr_count)
);

// File: tb/tb_wdg_backup_top.sv
module tb_wdg_backup_top;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 6;
  localparam int EM  = 8;
  localparam int ML  = 3;
  localparam int GL  = 3;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic svc = 1'b0;
  logic flag_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state: 0 off, 1 extended, 2 parked, 3 normal
  int m_st = 0, m_t = 0, m_miss = 0, m_good = 0, m_flag = 1, m_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_backup_top #(
    .PERIOD_TICKS (P),
    .EXT_MULT     (EM),
    .MISS_LIMIT   (ML),
    .GOOD_LIMIT   (GL)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_valid_i (en),
    .svc_i      (svc),
    .backup_n_o (flag_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_miss = 0; m_good = 0; m_flag = 1; m_prev = 0;
    end else begin
      bit f;
      f = (m_prev == 1) && (svc == 1'b0);
      m_prev = int'(svc);
      if (!en) begin
        m_st = 0; m_t = 0; m_miss = 0; m_good = 0; m_flag = 1;
      end else if (m_st == 0) begin
        m_st = 1; m_t = 0;
      end else if (m_st == 1) begin
        if (f) begin m_st = 3; m_t = 0; end
        else if (m_t == P*EM - 1) begin m_st = 2; m_t = 0; m_flag = 0; m_good = 0; m_miss = 0; end
        else m_t++;
      end else if (m_st == 2) begin
        if (f) begin m_st = 3; m_t = 0; m_miss = 0; m_good = 1; end
      end else begin
        if (f) begin
          m_t = 0; m_miss = 0;
          if (m_flag == 0) begin
            m_good++;
            if (m_good == GL) begin m_flag = 1; m_good = 0; end
          end
        end else if (m_t == P - 1) begin
          m_t = 0; m_good = 0;
          if (m_miss == ML - 1) m_flag = 0; else m_miss++;
        end else m_t++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(flag_n) != m_flag) begin
        errors++;
        $display("FAIL %s cycle %0d: backup_n_o=%0d expected %0d", tag, cycles, flag_n, m_flag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); svc = 1'b1;
    @(negedge clk); svc = 1'b0;
  endtask

  task automatic expect_flag(input logic exp, input string req);
    checks++;
    if (flag_n !== exp) begin
      errors++;
      $display("FAIL %s explicit: backup_n_o=%0d expected %0d", req, flag_n, exp);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_flag(1'b1, "R1");

    // R1: service toggling with enable low does nothing
    tag = "R1";
    for (int i = 0; i < 20; i++) pulse();
    idle(5);
    expect_flag(1'b1, "R1");

    // R2/R4: extended window with no service
    tag = "R2";
    en = 1'b1;
    idle(P*EM);
    expect_flag(1'b1, "R2");
    tag = "R4";
    idle(1);
    expect_flag(1'b0, "R4");
    idle(100);
    expect_flag(1'b0, "R4");

    // R5: first edge after expiry counts toward release
    tag = "R5";
    pulse(); idle(2);
    expect_flag(1'b0, "R5");
    tag = "R7";
    idle(1); pulse(); idle(2); pulse(); idle(1);
    expect_flag(1'b1, "R7");

    // R6: three silent periods
    tag = "R6";
    pulse();
    idle(ML*P);
    expect_flag(1'b1, "R6");
    idle(1);
    expect_flag(1'b0, "R6");

    // R7: a timeout between edges restarts the good count
    tag = "R7";
    pulse(); idle(2); pulse(); idle(P + 3); pulse(); idle(2);
    expect_flag(1'b0, "R7");
    pulse(); idle(2); pulse(); idle(1);
    expect_flag(1'b1, "R7");

    // R3: edge during extended window switches to normal period
    tag = "R3";
    en = 1'b0; idle(3);
    en = 1'b1; idle(20);
    pulse();
    idle(ML*P);
    expect_flag(1'b1, "R3");
    idle(1);
    expect_flag(1'b0, "R3");

    // R1: dropping enable clears a low flag and the fault state
    tag = "R1";
    en = 1'b0; idle(1);
    expect_flag(1'b1, "R1");
    en = 1'b1; idle(P*EM - 5);
    expect_flag(1'b1, "R1");
    en = 1'b0; idle(2);
    en = 1'b1; idle(P*EM);
    expect_flag(1'b1, "R2");
    idle(2);

    // R8/R9: service spacing swept across the period boundary
    for (int gap = 2; gap <= 6; gap++) begin
      tag = (gap == P - 2) ? "R9" : "R8";
      for (int k = 0; k < 8; k++) begin
        pulse(); idle(gap);
      end
      idle(ML*P + 2);
    end

    // R9: held-high service (no edge) still times out
    tag = "R9";
    svc = 1'b1; idle(ML*P*2);
    svc = 1'b0; idle(P);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule